// File: doc/BRIEF.md
# Accelerator Color Register Dual-Access Unit

This block is the small register bank that a 2D drawing engine reads its color operands and pixel masks from. It keeps four 32-bit registers: a background color, a foreground color, a write mask and a read mask. Software reaches them through a bus that is often narrower than 32 bits. Two further registers set how each access is handled:

- A system control register. Its bits [5:4] select the pixel depth.
- An accelerator control register. It holds a full-width enable bit (bit 9) and a half-select toggle bit (bit 4).

At 8 and 16 bits per pixel, only the low byte or the low halfword of a color register takes part in an access. At 32 bits per pixel with the full-width bit clear, a 32-bit value moves as two halfword accesses. One toggle bit steers those accesses, and all four color registers share it. On a write the half is chosen from the current toggle, and the toggle is inverted afterwards. On a read the toggle is inverted first, and the half is chosen from the inverted value. A 4-byte write always loads the whole register directly.

The bus is a plain synchronous port with no back-pressure: an access completes in the cycle its strobe is high. Read data is combinational from the address and the current state. The toggle side effect of a read takes place at the clock edge that ends the read cycle.

Address map:

| Address | Register |
|---|---|
| 0 | System control |
| 1 | Accelerator control |
| 2 | Background color |
| 3 | Foreground color |
| 4 | Write mask |
| 5 | Read mask |
| 6, 7 | Unmapped |

Access size codes: 00 is a byte, 01 is a halfword, 10 is a 4-byte word, and 11 is handled like a halfword.

Top module: `acb_color_bank`

## Requirements
- R1: The pixel depth comes from bits [5:4] of the system control register (address 0): 00 selects 8 bpp, 01 selects 16 bpp and 11 selects 32 bpp. The unused code 10 behaves exactly like 8 bpp.
- R2: At 8 bpp, a non-word write to a color register stores the data's low 8 bits and clears bits [31:8]. A read returns the register's low 8 bits, zero-extended.
- R3: At 16 bpp, a non-word write stores the data's low 16 bits and clears bits [31:16]. A read returns the register's low 16 bits, zero-extended.
- R4: At 32 bpp with control bit 9 set, a write replaces all 32 bits and a read returns all 32 bits. Neither access changes the toggle (control bit 4).
- R5: At 32 bpp with bit 9 clear, a non-word write goes to bits [31:16] if the toggle is 1, and to bits [15:0] if it is 0. The other half keeps its value, and the toggle is inverted at that edge.
- R6: At 32 bpp with bit 9 clear, a read inverts the toggle at its clock edge. The read returns bits [15:0] when the toggle before the read is 0 (the inverted toggle is 1). It returns bits [31:16] when the toggle before the read is 1. The returned half is zero-extended.
- R7: A write with access size 10 (4 bytes) to a color register loads all 32 data bits, whatever the depth and toggle are, and leaves the toggle unchanged.
- R8: All four color registers use one toggle, so half accesses to different registers advance a single sequence.
- R9: The system control register (8 bits, address 0) and the accelerator control register (16 bits, address 1) are written from the low data bits. They read back zero-extended. Writing address 1 sets the toggle directly from data bit 4.
- R10: Reset clears both control registers, the toggle and all four color registers.
- R11: While the write enable is high, the read strobe has no effect on the toggle. Accesses to addresses 0, 1, 6 and 7 never move the toggle. Writes to 6 and 7 change no register, and reads of 6 and 7 return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 3 | Register address |
| bus_we | input | 1 | Write enable, one access per cycle |
| bus_re | input | 1 | Read strobe; its toggle effect lands at the clock edge |
| bus_size | input | 2 | Access size: 00 byte, 01 halfword, 10 word, 11 halfword |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for the addressed register |

## Verification
The checker watches the toggle on every cycle. It must invert on each half-mode color write or lone half-mode read, and it must hold through full-width, word-size, narrow-depth, control and unmapped accesses. It also checks that narrow-depth reads carry no upper bits and that unmapped reads are zero. Only the bench scenarios can show which half a given access actually reached and that the other half survived. The same applies to interleaving across registers through the shared toggle and to the control registers' read-back. For those checks the bench reloads values and reads them back through the full-width path.

// File: rtl/acb_pkg.sv
package acb_pkg;

  // Decoded pixel depth, already folded from the raw two-bit code.
  typedef enum logic [1:0] {
    PIX8  = 2'd0,
    PIX16 = 2'd1,
    PIX32 = 2'd2
  } pix_mode_t;

  // Bus access size codes.
  localparam logic [1:0] SZ_BYTE = 2'b00;
  localparam logic [1:0] SZ_HALF = 2'b01;
  localparam logic [1:0] SZ_WORD = 2'b10;

  // Raw depth codes in the system control register.
  localparam logic [1:0] DEPTH_CODE_16 = 2'b01;
  localparam logic [1:0] DEPTH_CODE_32 = 2'b11;

endpackage

// File: rtl/acb_depth_decode.sv
module acb_depth_decode
  import acb_pkg::*;
#(
  parameter int SYS_W     = 8,
  parameter int DEPTH_LSB = 4
) (
  input  logic [SYS_W-1:0] sys_ctl,
  output pix_mode_t        pix_mode
);

  logic [1:0] code;

  assign code = sys_ctl[DEPTH_LSB +: 2];

  // The reserved code folds into the 8 bpp handling.
  always_comb begin
    unique case (code)
      DEPTH_CODE_16: pix_mode = PIX16;
      DEPTH_CODE_32: pix_mode = PIX32;
      default:       pix_mode = PIX8;
    endcase
  end

endmodule

// File: rtl/acb_ctrl_regs.sv
module acb_ctrl_regs #(
  parameter int DATA_W   = 32,
  parameter int SYS_W    = 8,
  parameter int CTRL_W   = 16,
  parameter int FULL_BIT = 9,
  parameter int TOG_BIT  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sys_we,
  input  logic              ctrl_we,
  input  logic              tog_flip,
  input  logic [DATA_W-1:0] wdata,
  output logic [SYS_W-1:0]  sys_q,
  output logic [CTRL_W-1:0] ctrl_q,
  output logic              full_en,
  output logic              tog
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sys_q <= '0;
    end else if (sys_we) begin
      sys_q <= wdata[SYS_W-1:0];
    end
  end

  // A direct control write wins over a sequencing flip.
  // Both cannot occur in the same cycle, because they use different addresses.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
    end else if (ctrl_we) begin
      ctrl_q <= wdata[CTRL_W-1:0];
    end else if (tog_flip) begin
      ctrl_q[TOG_BIT] <= ~ctrl_q[TOG_BIT];
    end
  end

  assign full_en = ctrl_q[FULL_BIT];
  assign tog     = ctrl_q[TOG_BIT];

endmodule

// File: rtl/acb_color_slot.sv
module acb_color_slot
  import acb_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic              word_wr,
  input  pix_mode_t         pix_mode,
  input  logic              full_en,
  input  logic              tog,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] q
);

  localparam int HALF_W = DATA_W / 2;

  logic [DATA_W-1:0] nxt;

  always_comb begin
    nxt = q;
    if (wr) begin
      if (word_wr) begin
        nxt = wdata;
      end else begin
        unique case (pix_mode)
          PIX16: nxt = DATA_W'(wdata[HALF_W-1:0]);
          PIX32: begin
            if (full_en) begin
              nxt = wdata;
            end else if (tog) begin
              nxt = {wdata[HALF_W-1:0], q[HALF_W-1:0]};
            end else begin
              nxt = {q[DATA_W-1:HALF_W], wdata[HALF_W-1:0]};
            end
          end
          default: nxt = DATA_W'(wdata[BYTE_W-1:0]);
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q <= '0;
    end else begin
      q <= nxt;
    end
  end

endmodule

// File: rtl/acb_read_fmt.sv
module acb_read_fmt
  import acb_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int BYTE_W  = 8,
  parameter int N_COLOR = 4,
  parameter int IDX_W   = 2
) (
  input  logic [N_COLOR-1:0][DATA_W-1:0] colors,
  input  logic [IDX_W-1:0]               idx,
  input  pix_mode_t                      pix_mode,
  input  logic                           full_en,
  input  logic                           tog,
  output logic [DATA_W-1:0]              fmt_data
);

  localparam int HALF_W = DATA_W / 2;

  logic [DATA_W-1:0] sel;

  assign sel = colors[idx];

  // In half mode the read sees the toggle after inversion.
  // A current value of 0 therefore selects the low half.
  always_comb begin
    unique case (pix_mode)
      PIX16: fmt_data = DATA_W'(sel[HALF_W-1:0]);
      PIX32: begin
        if (full_en) begin
          fmt_data = sel;
        end else if (tog) begin
          fmt_data = DATA_W'(sel[DATA_W-1:HALF_W]);
        end else begin
          fmt_data = DATA_W'(sel[HALF_W-1:0]);
        end
      end
      default: fmt_data = DATA_W'(sel[BYTE_W-1:0]);
    endcase
  end

endmodule

// File: rtl/acb_color_bank.sv
module acb_color_bank
  import acb_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int ADDR_W     = 3,
  parameter int SYS_W      = 8,
  parameter int CTRL_W     = 16,
  parameter int FULL_BIT   = 9,
  parameter int TOG_BIT    = 4,
  parameter int DEPTH_LSB  = 4,
  parameter int N_COLOR    = 4,
  parameter int COLOR_BASE = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic              bus_re,
  input  logic [1:0]        bus_size,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata
);

  localparam int IDX_W = (N_COLOR > 1) ? $clog2(N_COLOR) : 1;
  localparam logic [ADDR_W-1:0] A_SYS  = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_CLO  = ADDR_W'(COLOR_BASE);
  localparam logic [ADDR_W-1:0] A_CHI  = ADDR_W'(COLOR_BASE + N_COLOR);

  logic [SYS_W-1:0]               sys_q;
  logic [CTRL_W-1:0]              ctrl_q;
  logic                           full_en;
  logic                           tog_q;
  pix_mode_t                      pix_mode;
  logic                           is_color;
  logic [ADDR_W-1:0]              color_off;
  logic [IDX_W-1:0]               idx;
  logic                           half_mode;
  logic                           word_wr;
  logic                           tog_flip;
  logic [N_COLOR-1:0][DATA_W-1:0] colors;
  logic [DATA_W-1:0]              fmt_data;

  assign is_color  = (bus_addr >= A_CLO) && (bus_addr < A_CHI);
  assign color_off = bus_addr - A_CLO;
  assign idx       = color_off[IDX_W-1:0];
  assign half_mode = (pix_mode == PIX32) && !full_en;
  assign word_wr   = (bus_size == SZ_WORD);

  // The toggle advances on a half-mode color write that is not a word write,
  // or on a half-mode color read with no write in the same cycle.
  assign tog_flip = is_color && half_mode &&
                    ((bus_we && !word_wr) || (bus_re && !bus_we));

  acb_ctrl_regs #(
    .DATA_W  (DATA_W),
    .SYS_W   (SYS_W),
    .CTRL_W  (CTRL_W),
    .FULL_BIT(FULL_BIT),
    .TOG_BIT (TOG_BIT)
  ) u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .sys_we  (bus_we && (bus_addr == A_SYS)),
    .ctrl_we (bus_we && (bus_addr == A_CTRL)),
    .tog_flip(tog_flip),
    .wdata   (bus_wdata),
    .sys_q   (sys_q),
    .ctrl_q  (ctrl_q),
    .full_en (full_en),
    .tog     (tog_q)
  );

  acb_depth_decode #(
    .SYS_W    (SYS_W),
    .DEPTH_LSB(DEPTH_LSB)
  ) u_depth (
    .sys_ctl (sys_q),
    .pix_mode(pix_mode)
  );

  for (genvar g = 0; g < N_COLOR; g++) begin : g_slot
    acb_color_slot #(
      .DATA_W(DATA_W)
    ) u_slot (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr      (bus_we && is_color && (idx == IDX_W'(g))),
      .word_wr (word_wr),
      .pix_mode(pix_mode),
      .full_en (full_en),
      .tog     (tog_q),
      .wdata   (bus_wdata),
      .q       (colors[g])
    );
  end

  acb_read_fmt #(
    .DATA_W (DATA_W),
    .N_COLOR(N_COLOR),
    .IDX_W  (IDX_W)
  ) u_rfmt (
    .colors  (colors),
    .idx     (idx),
    .pix_mode(pix_mode),
    .full_en (full_en),
    .tog     (tog_q),
    .fmt_data(fmt_data)
  );

  always_comb begin
    if (bus_addr == A_SYS) begin
      bus_rdata = DATA_W'(sys_q);
    end else if (bus_addr == A_CTRL) begin
      bus_rdata = DATA_W'(ctrl_q);
    end else if (is_color) begin
      bus_rdata = fmt_data;
    end else begin
      bus_rdata = '0;
    end
  end

endmodule

// File: rtl/acb_color_bank_chk.sv
module acb_color_bank_chk
  import acb_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int ADDR_W     = 3,
  parameter int N_COLOR    = 4,
  parameter int COLOR_BASE = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_we,
  input logic              bus_re,
  input logic [1:0]        bus_size,
  input logic [DATA_W-1:0] bus_rdata,
  input pix_mode_t         pix_mode,
  input logic              full_en,
  input logic              tog_q
);

  localparam int HALF_W = DATA_W / 2;

  logic c_color;
  logic c_half;

  assign c_color = (bus_addr >= ADDR_W'(COLOR_BASE)) &&
                   (bus_addr < ADDR_W'(COLOR_BASE + N_COLOR));
  assign c_half  = (pix_mode == PIX32) && !full_en;

  assert_wr_flip_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && c_color && c_half && bus_size != SZ_WORD) |=> (tog_q != $past(tog_q)));

  assert_rd_flip_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_re && !bus_we && c_color && c_half) |=> (tog_q != $past(tog_q)));

  assert_full_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ((bus_we || bus_re) && c_color && !c_half) |=> $stable(tog_q));

  assert_word_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && c_color && bus_size == SZ_WORD) |=> $stable(tog_q));

  assert_idle_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_we && !bus_re) |=> $stable(tog_q));

  assert_narrow8_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_re && c_color && pix_mode == PIX8) |-> (bus_rdata[DATA_W-1:8] == '0));

  assert_narrow16_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_re && c_color && (pix_mode == PIX16 || c_half)) |->
      (bus_rdata[DATA_W-1:HALF_W] == '0));

  assert_unmapped_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_re && bus_addr >= ADDR_W'(COLOR_BASE + N_COLOR)) |-> (bus_rdata == '0));

endmodule

bind acb_color_bank acb_color_bank_chk #(
  .DATA_W    (DATA_W),
  .ADDR_W    (ADDR_W),
  .N_COLOR   (N_COLOR),
  .COLOR_BASE(COLOR_BASE)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .bus_addr (bus_addr),
  .bus_we   (bus_we),
  .bus_re   (bus_re),
  .bus_size (bus_size),
  .bus_rdata(bus_rdata),
  .pix_mode (pix_mode),
  .full_en  (full_en),
  .tog_q    (tog_q)
);

// File: tb/sim_acb_color_bank.sv
`timescale 1ns/1ps
module sim_acb_color_bank;

  localparam logic [2:0] A_SYS = 3'd0, A_CTRL = 3'd1, A_BG = 3'd2,
                         A_FG = 3'd3, A_WM = 3'd4, A_RM = 3'd5;
  localparam logic [1:0] S_B = 2'b00, S_H = 2'b01, S_W = 2'b10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic        bus_we = 1'b0;
  logic        bus_re = 1'b0;
  logic [1:0]  bus_size = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  int n_chk = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  acb_color_bank u0 (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_re(bus_re), .bus_size(bus_size), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [1:0] sz, logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_size = sz; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(logic [2:0] a, logic [31:0] exp, string req);
    @(negedge clk);
    bus_addr = a; bus_re = 1'b1;
    #1;
    check(req, bus_rdata, exp);
    @(negedge clk);
    bus_re = 1'b0;
  endtask

  // Full 32-bit view of a color register, restoring the control value after.
  task automatic peek_full(logic [2:0] a, logic [31:0] exp, logic [15:0] ctrl_after, string req);
    wr(A_CTRL, S_H, 32'h0000_0200);
    rd(a, exp, req);
    wr(A_CTRL, S_H, {16'h0, ctrl_after});
  endtask

  task automatic t_reset();
    rd(A_SYS,  32'h0, "R10 sys");
    rd(A_CTRL, 32'h0, "R10 ctrl");
    for (int i = 2; i < 6; i++) rd(3'(i), 32'h0, "R10 color");
    wr(A_SYS, S_B, 32'h30);
    for (int i = 2; i < 6; i++) peek_full(3'(i), 32'h0, 16'h0, "R10 color full");
    wr(A_SYS, S_B, 32'h00);
  endtask

  task automatic t_depth8();
    wr(A_SYS, S_B, 32'h00);
    wr(A_BG, S_H, 32'hAABB_CCDD);
    rd(A_BG, 32'h0000_00DD, "R2 read8");
    rd(A_CTRL, 32'h0, "R2 toggle held");
    wr(A_SYS, S_B, 32'h20);
    wr(A_FG, S_H, 32'h1234_5678);
    rd(A_FG, 32'h0000_0078, "R1 reserved as 8bpp");
    wr(A_SYS, S_B, 32'h30);
    peek_full(A_FG, 32'h0000_0078, 16'h0, "R2 upper cleared");
  endtask

  task automatic t_depth16();
    wr(A_SYS, S_B, 32'h10);
    wr(A_WM, S_H, 32'hCAFE_BABE);
    rd(A_WM, 32'h0000_BABE, "R3 read16");
    wr(A_WM, S_W, 32'h1122_3344);
    rd(A_WM, 32'h0000_3344, "R7 word write, read16");
    wr(A_SYS, S_B, 32'h30);
    peek_full(A_WM, 32'h1122_3344, 16'h0, "R7 word full value");
  endtask

  task automatic t_full32();
    wr(A_SYS, S_B, 32'h30);
    wr(A_CTRL, S_H, 32'h0000_0200);
    wr(A_RM, S_H, 32'hDEAD_BEEF);
    rd(A_RM, 32'hDEAD_BEEF, "R4 full read");
    rd(A_CTRL, 32'h0000_0200, "R4 toggle held");
  endtask

  task automatic t_half32();
    wr(A_SYS, S_B, 32'h30);
    wr(A_CTRL, S_H, 32'h0);
    wr(A_BG, S_H, 32'h0000_1111);
    rd(A_CTRL, 32'h0000_0010, "R5 toggle set after low write");
    wr(A_BG, S_H, 32'h0000_2222);
    rd(A_CTRL, 32'h0000_0000, "R5 toggle cleared after high write");
    rd(A_BG, 32'h0000_1111, "R6 first read low");
    rd(A_CTRL, 32'h0000_0010, "R6 toggle after read");
    rd(A_BG, 32'h0000_2222, "R6 second read high");
    peek_full(A_BG, 32'h2222_1111, 16'h0010, "R5 halves");
    wr(A_BG, S_H, 32'h0000_3333);
    peek_full(A_BG, 32'h3333_1111, 16'h0010, "R5 low preserved");
    rd(A_BG, 32'h0000_3333, "R6 read from toggle 1 gives high");
  endtask

  task automatic t_shared();
    wr(A_CTRL, S_H, 32'h0);
    wr(A_FG, S_H, 32'h0000_AAAA);
    wr(A_WM, S_H, 32'h0000_BBBB);
    rd(A_CTRL, 32'h0, "R8 toggle shared");
    peek_full(A_FG, 32'h0000_AAAA, 16'h0, "R8 fg low");
    peek_full(A_WM, 32'hBBBB_3344, 16'h0, "R8 wm high");
  endtask

  task automatic t_word32();
    wr(A_CTRL, S_H, 32'h0000_0010);
    wr(A_RM, S_W, 32'h0102_0304);
    rd(A_CTRL, 32'h0000_0010, "R7 toggle held");
    peek_full(A_RM, 32'h0102_0304, 16'h0, "R7 full load");
  endtask

  task automatic t_ctrl();
    wr(A_CTRL, S_W, 32'hFFFF_1234);
    rd(A_CTRL, 32'h0000_1234, "R9 ctrl readback");
    wr(A_SYS, S_W, 32'hFFFF_FFF5);
    rd(A_SYS, 32'h0000_00F5, "R9 sys readback");
    rd(A_CTRL, 32'h0000_1234, "R9 sys write leaves ctrl");
  endtask

  task automatic t_misc();
    wr(A_SYS, S_B, 32'h30);
    wr(A_CTRL, S_H, 32'h0);
    @(negedge clk);
    bus_addr = A_BG; bus_size = S_H; bus_wdata = 32'h0000_5555;
    bus_we = 1'b1; bus_re = 1'b1;
    @(negedge clk);
    bus_we = 1'b0; bus_re = 1'b0;
    rd(A_CTRL, 32'h0000_0010, "R11 write wins over read");
    wr(3'd6, S_W, 32'hFFFF_FFFF);
    rd(3'd7, 32'h0, "R11 unmapped read");
    rd(3'd6, 32'h0, "R11 unmapped write ignored");
    rd(A_CTRL, 32'h0000_0010, "R11 toggle held on unmapped");
    peek_full(A_BG, 32'h3333_5555, 16'h0, "R11 only write applied");
  endtask

  initial begin
    #(4 * 200000);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_depth8();
    t_depth16();
    t_full32();
    t_half32();
    t_shared();
    t_word32();
    t_ctrl();
    t_misc();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule